// File: doc/BRIEF.md
# ROM/Flash Chip-Select Cycle Controller

This block sits between the CPU's memory request path and up to three external ROM or Flash regions. The two address bits directly above a 26-bit (64 Mbyte) offset choose one of three regions. Each region carries its own configuration: data width (8, 16 or 32 bits), write protection, a slow ISA-like timing or a fast CPU-clock timing, and a wait-state count. For every accepted request the block asserts the matching chip select and the dedicated ROM read or ROM write strobe for the programmed number of clocks. It pulses `rdy` at the end of every beat and presents the current beat address.

A cache-line refill (a read with `req_burst` set) is served as one 16-byte line. On a 16- or 32-bit region in fast timing the beats run back to back as page-mode reads, with the chip select and read strobe held low throughout. On any other region the line is split into separate cycles, with a one-clock release of the strobes between them. The first two regions can each be moved to a PC Card socket select by a redirect bit. A write to a protected region runs its normal timing with the chip select asserted, but the write strobe is never asserted. The write completes with `rdy` and raises `wp_violation` for that cycle.

Requests form a valid/ready stream. `req_ready` is high only while the block is idle and the presented address falls in one of the three regions. A request is taken on a clock edge where both signals are high. Address, direction and burst are captured at that edge, so the requester may change them afterwards. While a cycle runs, `req_ready` stays low and further requests wait. The configuration inputs are expected to stay static while a cycle is in progress.

Top module: `romcs_cycle_ctrl`

## Requirements
- R1: Address bits [27:26] select the region. Values 0, 1 and 2 drive `rom_cs_n[0]`, `rom_cs_n[1]` and `rom_cs_n[2]` low, respectively, for the duration of the cycle. Value 3 is never accepted: `req_ready` stays low and no strobe moves.
- R2: At most one of `rom_cs_n[2:0]` and `card_cs_n` is low at any time. If `cfg_redirect[i]` is set for region i (i = 0 or 1), that region's cycles drive `card_cs_n` instead of its own chip select. Region 2 has no redirect.
- R3: A single access to a region in slow timing (`cfg_fast` bit = 0) holds its strobe low for 3 + w clocks, where w is that region's 3-bit wait field. `rdy` is high in the last of those clocks only.
- R4: A single access to a region in fast timing (`cfg_fast` bit = 1) holds its strobe low for 1 + w clocks, w from 0 to 7. `rdy` is high in the last clock only.
- R5: A write drives `rom_wr_n` low and a read drives `rom_rd_n` low, never both at once. A write to a region whose `cfg_wprot` bit is set keeps `rom_wr_n` high, still asserts the chip select for the full timing, completes with `rdy`, and raises `wp_violation` in that `rdy` clock only. Protection bits of other regions have no effect.
- R6: A burst read on a fast region 16 or 32 bits wide is a page burst of 8 or 4 beats, respectively. The chip select and `rom_rd_n` stay low without a break, and each beat lasts 1 + w clocks with `rdy` in its last clock.
- R7: A burst read on any other region is split into 16, 8 or 4 separate beats, for 8-, 16- or 32-bit regions respectively. Each beat uses the single-access timing of R3 or R4, with one clock between beats in which all strobes are high and `rdy` is low.
- R8: During a burst, `rom_addr` starts at the request address with bits [3:0] cleared and advances by the region's byte width (1, 2 or 4) after each beat. For a single access, `rom_addr` equals the request address. `rdy_last` accompanies `rdy` on the final beat only, and the clock after it shows all strobes high.
- R9: `req_ready` is low from acceptance until the clock after the final `rdy`. A burst request with `req_write` set is served as one single write.
- R10: While `rst_n` is low, all chip selects and strobes are high and `rdy`, `rdy_last` and `wp_violation` are low. After reset, `req_ready` follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid is high |
| req_addr | input | 28 | Byte address; bits [27:26] choose the region |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Cache-line refill request |
| cfg_width | input | 6 | Two bits per region (region i at [2i+1:2i]): 00 = 8, 01 = 16, 1x = 32 bits |
| cfg_fast | input | 3 | Per region: 1 = fast CPU-clock timing, 0 = slow timing |
| cfg_wait | input | 9 | Three wait-state bits per region (region i at [3i+2:3i]) |
| cfg_wprot | input | 3 | Per-region write protection |
| cfg_redirect | input | 2 | Redirect regions 0 and 1 to the card socket select |
| rom_cs_n | output | 3 | Active-low region chip selects |
| card_cs_n | output | 1 | Active-low card socket select |
| rom_rd_n | output | 1 | Active-low ROM read strobe |
| rom_wr_n | output | 1 | Active-low ROM write strobe |
| rom_addr | output | 28 | Current beat address |
| rdy | output | 1 | Beat complete |
| rdy_last | output | 1 | Final beat of the request |
| wp_violation | output | 1 | Write to a protected region, in its rdy clock |

## Verification
Two sets of events can fall in the same clock. In a page burst, the `rdy` that ends one beat coincides with a fresh timer load and an address step for the next beat, while the strobes must not lift. In a protected write, the completing `rdy` coincides with `wp_violation` while the chip select is low and the write strobe stays high. A sweep over every region, width, timing, wait count and operation, including protected writes and burst writes, lines up both cases. Every clock of every cycle is compared against an expected trace built arithmetically from beat count, beat length, gap placement and address step, so any missed, early or extra strobe edge at a beat boundary shows up.

// File: rtl/romcs_pkg.sv
package romcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_GAP  = 2'd2
  } cyc_state_t;

  // log2 of the byte width: 00 -> 8 bit, 01 -> 16 bit, 1x -> 32 bit
  function automatic logic [1:0] width_shift(input logic [1:0] w);
    return w[1] ? 2'd2 : (w[0] ? 2'd1 : 2'd0);
  endfunction

endpackage

// File: rtl/rom_space_decode.sv
module rom_space_decode #(
  parameter int NSP       = 3,
  parameter int SEL_W     = 2,
  parameter int WAIT_W    = 3,
  parameter int NUM_REMAP = 2
) (
  input  logic [SEL_W-1:0]      region,
  input  logic [2*NSP-1:0]      cfg_width,
  input  logic [NSP-1:0]        cfg_fast,
  input  logic [WAIT_W*NSP-1:0] cfg_wait,
  input  logic [NSP-1:0]        cfg_wprot,
  input  logic [NUM_REMAP-1:0]  cfg_redirect,
  output logic                  hit,
  output logic [SEL_W-1:0]      sp,
  output logic [1:0]            width,
  output logic                  fast,
  output logic [WAIT_W-1:0]     wt,
  output logic                  wprot,
  output logic                  redirect
);

  always_comb begin
    hit   = 1'b0;
    sp    = region;
    width = '0;
    fast  = 1'b0;
    wt    = '0;
    wprot = 1'b0;
    for (int i = 0; i < NSP; i++) begin
      if (region == SEL_W'(i)) begin
        hit   = 1'b1;
        width = cfg_width[2*i +: 2];
        fast  = cfg_fast[i];
        wt    = cfg_wait[WAIT_W*i +: WAIT_W];
        wprot = cfg_wprot[i];
      end
    end
  end

  always_comb begin
    redirect = 1'b0;
    for (int j = 0; j < NUM_REMAP; j++) begin
      if (region == SEL_W'(j)) redirect = cfg_redirect[j];
    end
  end

endmodule

// File: rtl/rom_burst_plan.sv
module rom_burst_plan
  import romcs_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int BEAT_W     = 4
) (
  input  logic              burst,
  input  logic              write,
  input  logic              fast,
  input  logic [1:0]        width,
  output logic              is_burst,
  output logic              page,
  output logic [1:0]        shift,
  output logic [BEAT_W-1:0] beats_m1
);

  always_comb begin
    shift    = width_shift(width);
    is_burst = burst && !write;
    page     = is_burst && fast && (shift != 2'd0);
    beats_m1 = is_burst ? BEAT_W'((LINE_BYTES >> shift) - 1) : '0;
  end

endmodule

// File: rtl/rom_beat_timer.sv
module rom_beat_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/romcs_cycle_ctrl.sv
module romcs_cycle_ctrl
  import romcs_pkg::*;
#(
  parameter int NUM_SPACES  = 3,
  parameter int SPACE_AW    = 26,
  parameter int WAIT_W      = 3,
  parameter int NORMAL_CLKS = 3,
  parameter int LINE_BYTES  = 16,
  parameter int NUM_REMAP   = 2,
  localparam int SEL_W      = $clog2(NUM_SPACES + 1),
  localparam int ADDR_W     = SPACE_AW + SEL_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic                         req_write,
  input  logic                         req_burst,
  input  logic [2*NUM_SPACES-1:0]      cfg_width,
  input  logic [NUM_SPACES-1:0]        cfg_fast,
  input  logic [WAIT_W*NUM_SPACES-1:0] cfg_wait,
  input  logic [NUM_SPACES-1:0]        cfg_wprot,
  input  logic [NUM_REMAP-1:0]         cfg_redirect,
  output logic [NUM_SPACES-1:0]        rom_cs_n,
  output logic                         card_cs_n,
  output logic                         rom_rd_n,
  output logic                         rom_wr_n,
  output logic [ADDR_W-1:0]            rom_addr,
  output logic                         rdy,
  output logic                         rdy_last,
  output logic                         wp_violation
);

  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int BEAT_W  = LINE_SH;
  localparam int CNT_W   = $clog2(NORMAL_CLKS + (1 << WAIT_W));

  // decode of the presented request
  logic              dec_hit, dec_fast, dec_wp, dec_redir;
  logic [SEL_W-1:0]  dec_sp;
  logic [1:0]        dec_width;
  logic [WAIT_W-1:0] dec_wait;

  rom_space_decode #(
    .NSP(NUM_SPACES), .SEL_W(SEL_W), .WAIT_W(WAIT_W), .NUM_REMAP(NUM_REMAP)
  ) u_decode (
    .region      (req_addr[ADDR_W-1 -: SEL_W]),
    .cfg_width   (cfg_width),
    .cfg_fast    (cfg_fast),
    .cfg_wait    (cfg_wait),
    .cfg_wprot   (cfg_wprot),
    .cfg_redirect(cfg_redirect),
    .hit         (dec_hit),
    .sp          (dec_sp),
    .width       (dec_width),
    .fast        (dec_fast),
    .wt          (dec_wait),
    .wprot       (dec_wp),
    .redirect    (dec_redir)
  );

  logic              pl_burst, pl_page;
  logic [1:0]        pl_shift;
  logic [BEAT_W-1:0] pl_beats_m1;

  rom_burst_plan #(.LINE_BYTES(LINE_BYTES), .BEAT_W(BEAT_W)) u_plan (
    .burst   (req_burst),
    .write   (req_write),
    .fast    (dec_fast),
    .width   (dec_width),
    .is_burst(pl_burst),
    .page    (pl_page),
    .shift   (pl_shift),
    .beats_m1(pl_beats_m1)
  );

  // cycle state
  cyc_state_t        st;
  logic [SEL_W-1:0]  sp_q;
  logic              write_q, wprot_q, card_q, fast_q, page_q;
  logic [WAIT_W-1:0] wait_q;
  logic [1:0]        shift_q;
  logic [BEAT_W-1:0] beats_left;
  logic [ADDR_W-1:0] addr_q;

  function automatic logic [CNT_W-1:0] len_m1(input logic f, input logic [WAIT_W-1:0] w);
    return f ? CNT_W'(w) : CNT_W'(w) + CNT_W'(NORMAL_CLKS - 1);
  endfunction

  logic act, accept, tmr_done, tmr_load;
  logic [CNT_W-1:0] tmr_val;

  assign act       = (st == ST_ACT);
  assign req_ready = (st == ST_IDLE) && dec_hit;
  assign accept    = req_valid && req_ready;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = len_m1(fast_q, wait_q);
    if (st == ST_IDLE) begin
      tmr_load = accept;
      tmr_val  = len_m1(dec_fast, dec_wait);
    end else if (st == ST_GAP) begin
      tmr_load = 1'b1;
    end else begin
      tmr_load = tmr_done && (beats_left != '0) && page_q;
    end
  end

  rom_beat_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      sp_q       <= '0;
      write_q    <= 1'b0;
      wprot_q    <= 1'b0;
      card_q     <= 1'b0;
      fast_q     <= 1'b0;
      page_q     <= 1'b0;
      wait_q     <= '0;
      shift_q    <= '0;
      beats_left <= '0;
      addr_q     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st         <= ST_ACT;
          sp_q       <= dec_sp;
          write_q    <= req_write;
          wprot_q    <= dec_wp;
          card_q     <= dec_redir;
          fast_q     <= dec_fast;
          wait_q     <= dec_wait;
          page_q     <= pl_page;
          shift_q    <= pl_shift;
          beats_left <= pl_beats_m1;
          addr_q     <= pl_burst ? {req_addr[ADDR_W-1:LINE_SH], {LINE_SH{1'b0}}} : req_addr;
        end
        ST_ACT: if (tmr_done) begin
          if (beats_left == '0) begin
            st <= ST_IDLE;
          end else begin
            beats_left <= beats_left - 1'b1;
            addr_q     <= addr_q + (ADDR_W'(1) << shift_q);
            st         <= page_q ? ST_ACT : ST_GAP;
          end
        end
        default: st <= ST_ACT;
      endcase
    end
  end

  // strobes
  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_cs
    assign rom_cs_n[g] = !(act && !card_q && (sp_q == SEL_W'(g)));
  end

  assign card_cs_n    = !(act && card_q);
  assign rom_rd_n     = !(act && !write_q);
  assign rom_wr_n     = !(act && write_q && !wprot_q);
  assign rom_addr     = addr_q;
  assign rdy          = act && tmr_done;
  assign rdy_last     = rdy && (beats_left == '0);
  assign wp_violation = rdy && write_q && wprot_q;

  // checks
  AST_REGION_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr[ADDR_W-1 -: SEL_W] >= SEL_W'(NUM_SPACES)) |-> !req_ready); // R1
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~rom_cs_n, ~card_cs_n})); // R2
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_rd_n && !rom_wr_n)); // R5
  AST_WR_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_wr_n |-> !cfg_wprot[sp_q]); // R5
  AST_VIOL_AT_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    wp_violation |-> (rdy && rom_wr_n)); // R5
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !rdy_last && page_q) |=> !rom_rd_n); // R6
  AST_GAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !rdy_last && !page_q) |=> (rom_rd_n && !rdy)); // R7
  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_last |=> (&rom_cs_n && card_cs_n && rom_rd_n && rom_wr_n)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&rom_cs_n && card_cs_n)); // R9

endmodule

// File: tb/tb_romcs_cycle_ctrl.sv
module tb_romcs_cycle_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_burst;
  logic [27:0] req_addr, rom_addr;
  logic [5:0]  cfg_width;
  logic [2:0]  cfg_fast, cfg_wprot, rom_cs_n;
  logic [8:0]  cfg_wait;
  logic [1:0]  cfg_redirect;
  logic        card_cs_n, rom_rd_n, rom_wr_n, rdy, rdy_last, wp_violation;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  romcs_cycle_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_burst(req_burst),
    .cfg_width(cfg_width), .cfg_fast(cfg_fast), .cfg_wait(cfg_wait),
    .cfg_wprot(cfg_wprot), .cfg_redirect(cfg_redirect), .rom_cs_n(rom_cs_n),
    .card_cs_n(card_cs_n), .rom_rd_n(rom_rd_n), .rom_wr_n(rom_wr_n),
    .rom_addr(rom_addr), .rdy(rdy), .rdy_last(rdy_last), .wp_violation(wp_violation)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "cs idle", {28'd0, rom_cs_n, card_cs_n}, 32'hF);
    chk(tag, "rd/wr idle", {rom_rd_n, rom_wr_n}, 2'b11);
    chk(tag, "rdy flags idle", {rdy, rdy_last, wp_violation}, 3'b000);
  endtask

  // op: 0 read, 1 write, 2 protected write, 3 burst read, 4 burst write
  task automatic run_txn(input int sp, input int wd, input int fst, input int wt, input int op);
    logic wr, bst, wp, be, page, redir;
    logic [2:0] ecs;
    logic [27:0] a, start;
    int nb, len;
    string tg;
    wr    = (op == 1) || (op == 2) || (op == 4);
    bst   = (op >= 3);
    wp    = (op == 2);
    be    = bst && !wr;
    page  = be && (fst != 0) && (wd != 0);
    nb    = be ? (16 >> wd) : 1;
    len   = (fst != 0) ? 1 + wt : 3 + wt;
    redir = (sp < 2) && wt[0];
    a     = {2'(sp), 22'(wt * 4099 + op * 131 + wd * 17), 4'(wt * 3 + op + wd)};
    start = be ? (a & ~28'hF) : a;
    ecs   = redir ? 3'b111 : ~(3'b001 << sp);
    tg    = page ? "R6" : (be ? "R7" : ((fst != 0) ? "R4" : "R3"));

    @(negedge clk);
    cfg_width    = {3{2'(wd)}};
    cfg_fast     = {3{fst[0]}};
    cfg_wait     = {3{3'(wt)}};
    cfg_wprot    = wp ? (3'b001 << sp) : (3'b111 & ~(3'b001 << sp)); // R5: others protected, no effect
    cfg_redirect = {2{wt[0]}};
    req_addr     = a;
    req_write    = wr;
    req_burst    = bst;
    req_valid    = 1'b1;
    #1 chk("R9", "ready when idle", req_ready, 1);
    @(posedge clk);
    for (int b = 0; b < nb; b++) begin
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R1", "region select", rom_cs_n, ecs);
        chk("R2", "card select", card_cs_n, !redir);
        chk("R5", "rd/wr", {rom_rd_n, rom_wr_n}, {wr, !(wr && !wp)});
        chk(tg, "rdy timing", rdy, c == len - 1);
        chk("R8", "rdy_last", rdy_last, (c == len - 1) && (b == nb - 1));
        chk("R5", "violation", wp_violation, (c == len - 1) && wp);
        chk("R8", "beat address", rom_addr, start + 28'(b << wd));
        chk("R9", "busy ready", req_ready, 0);
        if (op == 4 && c == len - 1) chk("R9", "burst write single", rdy_last, 1);
      end
      if (!page && b < nb - 1) begin
        @(negedge clk);
        #1 chk_idle("R7");
      end
    end
    @(negedge clk);
    #1 chk_idle("R8");
    chk("R9", "ready after last", req_ready, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_err++;
    $display("FAIL R9 watchdog: actual=hung expected=complete");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_burst = 1'b0;
    cfg_width = '0; cfg_fast = '0; cfg_wait = '0; cfg_wprot = '0; cfg_redirect = '0;
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    #1 chk_idle("R10");
    @(negedge clk);
    req_valid = 1'b0;
    #1 chk_idle("R10");
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R10", "ready after reset", req_ready, 1);
    chk_idle("R10");

    // R1: fourth region never accepted
    @(negedge clk);
    req_addr = {2'b11, 26'h0ABCDE}; req_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1 chk("R1", "region 3 ready", req_ready, 0);
      chk_idle("R1");
      @(negedge clk);
    end
    req_valid = 1'b0;

    for (int sp = 0; sp < 3; sp++)
      for (int wd = 0; wd < 3; wd++)
        for (int fst = 0; fst < 2; fst++)
          for (int wt = 0; wt < 8; wt++)
            for (int op = 0; op < 5; op++)
              run_txn(sp, wd, fst, wt, op);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule